// File: doc/BRIEF.md
# Processor exception entry controller

This block performs the state update a processor core makes when it takes a general exception or a debug exception. On a raise strobe it captures the faulting PC, the cause code and, when present, the faulting virtual address. It also updates the status fields it holds: exception mode, user mode and interrupt level. It then reports which vector the core must fetch from, together with a one-cycle redirect strobe. All updates for a raise land on the same clock edge.

A debug exception is accepted only while the current interrupt level is below the configured debug level. When it is accepted, the old status word is saved into the save slot for that level, and the status moves up to the debug level. A general exception picks its save register and vector from the exception-mode and user-mode bits. A core that is already in exception mode takes the double vector. The core can also load the status fields directly, for example when it returns from a handler. Such a load is dropped in any cycle where an exception is taken.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, on each rising edge: exception mode, user mode, interrupt level, every save register and `redirect_o` are cleared to 0, and `vector_o` is cleared to 0.
- R2: A general raise (`exc_raise`) taken with exception mode clear writes `exc_pc` to `epc1_o`. It selects `vector_o` = 0 (user) if user mode is set, otherwise 1 (kernel).
- R3: A general raise taken with exception mode already set writes `exc_pc` to `depc_o` when `HAS_DEPC` is 1, and to `epc1_o` when it is 0. It selects `vector_o` = 2 (double). With `HAS_DEPC` = 1, `epc1_o` keeps its value.
- R4: Every general raise that is taken writes `exc_cause` to `exccause_o` and sets exception mode.
- R5: A general raise taken with `exc_vaddr_valid` high writes `exc_vaddr` to `excvaddr_o`. When `exc_vaddr_valid` is low, `excvaddr_o` keeps its value.
- R6: A debug raise (`dbg_raise`) is accepted only when the interrupt level is strictly below `DEBUG_LEVEL`. A refused debug raise changes no register. If a general raise arrives in the same cycle, that general raise is handled as if it were alone.
- R7: An accepted debug raise does four things. It writes `dbg_cause` to `dbgcause_o`. It writes `exc_pc` to the level slot of `epc_lvl_o`. It writes the old status word to the level slot of `eps_lvl_o`. It selects `vector_o` = 3 (debug). The status word is {um, excm, ilvl[2:0]}, 5 bits. The slot for level L sits at index L-2 of the flattened buses.
- R8: An accepted debug raise sets the interrupt level to `DEBUG_LEVEL` and sets exception mode. User mode is left unchanged.
- R9: When a general raise and an accepted debug raise arrive in the same cycle, only the debug entry happens. `epc1_o`, `depc_o`, `exccause_o` and `excvaddr_o` keep their values.
- R10: `redirect_o` is high for exactly the one cycle after each taken raise, and low otherwise. `vector_o` keeps its last value between raises.
- R11: `st_wr` loads `st_wdata` ({um, excm, ilvl[2:0]}) into the status fields on the next edge. The load is ignored in a cycle where a raise is taken.
- R12: The `epc_lvl_o` and `eps_lvl_o` slots for levels other than `DEBUG_LEVEL` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_raise | input | 1 | General exception raise strobe |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_pc | input | XLEN | Faulting PC, shared by both raises |
| exc_vaddr_valid | input | 1 | Raise carries a faulting virtual address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| dbg_raise | input | 1 | Debug exception raise strobe |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| st_wr | input | 1 | Direct status load strobe |
| st_wdata | input | 5 | Status word to load {um, excm, ilvl} |
| excm_o | output | 1 | Exception-mode bit |
| um_o | output | 1 | User-mode bit |
| ilvl_o | output | 3 | Current interrupt level |
| epc1_o | output | XLEN | First-level exception PC |
| depc_o | output | XLEN | Double-exception PC |
| exccause_o | output | CAUSE_W | Saved general cause |
| excvaddr_o | output | XLEN | Saved faulting virtual address |
| dbgcause_o | output | DCAUSE_W | Saved debug cause |
| epc_lvl_o | output | 6*XLEN | Per-level PCs, levels 2..7 |
| eps_lvl_o | output | 6*5 | Per-level saved status words, levels 2..7 |
| vector_o | output | 2 | Vector select: 0 user, 1 kernel, 2 double, 3 debug |
| redirect_o | output | 1 | One-cycle redirect strobe |

## Verification
Every result of a raise or a status load is registered, so it becomes visible one clock edge after the cycle in which the stimulus is driven. The redirect strobe falls again one edge later. The driver applies each stimulus at a falling edge and pushes the full expected output set for that edge into a queue. The monitor pops that entry 1 ns after the next rising edge and compares every output. This keeps each comparison exactly one edge behind its stimulus. The refused-debug and dropped-load cases are judged from the whole register set on that same edge.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int ILVL_W = 3;
  localparam int MIN_LVL = 2;
  localparam int MAX_LVL = 7;
  localparam int NLVL = MAX_LVL - MIN_LVL + 1;

  typedef enum logic [1:0] {
    VEC_USER   = 2'd0,
    VEC_KERNEL = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_GEN  = 2'd1,
    ACT_DBG  = 2'd2
  } act_e;

  typedef struct packed {
    logic              um;
    logic              excm;
    logic [ILVL_W-1:0] ilvl;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6
) (
  input  logic  exc_raise,
  input  logic  dbg_raise,
  input  stat_t stat,
  output act_e  act,
  output vec_e  vec_nxt
);

  localparam logic [ILVL_W-1:0] DL_V = ILVL_W'(DEBUG_LEVEL);

  logic dbg_ok;

  always_comb begin
    dbg_ok = dbg_raise && (stat.ilvl < DL_V);
    if (dbg_ok)         act = ACT_DBG;
    else if (exc_raise) act = ACT_GEN;
    else                act = ACT_NONE;

    if (dbg_ok)         vec_nxt = VEC_DEBUG;
    else if (stat.excm) vec_nxt = VEC_DOUBLE;
    else if (stat.um)   vec_nxt = VEC_USER;
    else                vec_nxt = VEC_KERNEL;
  end

endmodule

// File: rtl/exc_gen_save.sv
module exc_gen_save #(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_gen,
  input  logic               excm_now,
  input  logic [XLEN-1:0]    pc,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               vaddr_valid,
  input  logic [XLEN-1:0]    vaddr,
  output logic [XLEN-1:0]    epc1,
  output logic [XLEN-1:0]    depc,
  output logic [CAUSE_W-1:0] exccause,
  output logic [XLEN-1:0]    excvaddr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      exccause <= '0;
      excvaddr <= '0;
    end else if (take_gen) begin
      exccause <= cause;
      if (vaddr_valid) excvaddr <= vaddr;
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk) begin
        if (rst) begin
          epc1 <= '0;
          depc <= '0;
        end else if (take_gen) begin
          if (excm_now) depc <= pc;
          else          epc1 <= pc;
        end
      end

      // R3
      double_to_depc_chk: assert property (@(posedge clk) disable iff (rst)
        (take_gen && excm_now) |=> (depc == $past(pc)) && $stable(epc1));
    end else begin : g_nodepc
      always_ff @(posedge clk) begin
        if (rst)           epc1 <= '0;
        else if (take_gen) epc1 <= pc;
      end
      assign depc = '0;
    end
  endgenerate

  // R2
  first_to_epc1_chk: assert property (@(posedge clk) disable iff (rst)
    (take_gen && !excm_now) |=> (epc1 == $past(pc)));

  // R5
  vaddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(take_gen && vaddr_valid)) |=> $stable(excvaddr));

endmodule

// File: rtl/exc_dbg_save.sv
module exc_dbg_save
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DCAUSE_W    = 6,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take_dbg,
  input  logic [XLEN-1:0]        pc,
  input  logic [DCAUSE_W-1:0]    dcause,
  input  stat_t                  old_stat,
  output logic [DCAUSE_W-1:0]    dbgcause,
  output logic [NLVL*XLEN-1:0]   epc_lvl,
  output logic [NLVL*STAT_W-1:0] eps_lvl
);

  always_ff @(posedge clk) begin
    if (rst)           dbgcause <= '0;
    else if (take_dbg) dbgcause <= dcause;
  end

  generate
    for (genvar lv = MIN_LVL; lv <= MAX_LVL; lv++) begin : g_lvl
      localparam int IDX = lv - MIN_LVL;
      if (lv == DEBUG_LEVEL) begin : g_live
        always_ff @(posedge clk) begin
          if (rst) begin
            epc_lvl[IDX*XLEN +: XLEN]     <= '0;
            eps_lvl[IDX*STAT_W +: STAT_W] <= '0;
          end else if (take_dbg) begin
            epc_lvl[IDX*XLEN +: XLEN]     <= pc;
            eps_lvl[IDX*STAT_W +: STAT_W] <= old_stat;
          end
        end

        // R7
        eps_saves_old_chk: assert property (@(posedge clk) disable iff (rst)
          take_dbg |=> (eps_lvl[IDX*STAT_W +: STAT_W] == $past(old_stat)));
      end else begin : g_tied
        assign epc_lvl[IDX*XLEN +: XLEN]     = '0;
        assign eps_lvl[IDX*STAT_W +: STAT_W] = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       exc_raise,
  input  logic [CAUSE_W-1:0]         exc_cause,
  input  logic [XLEN-1:0]            exc_pc,
  input  logic                       exc_vaddr_valid,
  input  logic [XLEN-1:0]            exc_vaddr,
  input  logic                       dbg_raise,
  input  logic [DCAUSE_W-1:0]        dbg_cause,
  input  logic                       st_wr,
  input  logic [STAT_W-1:0]          st_wdata,
  output logic                       excm_o,
  output logic                       um_o,
  output logic [ILVL_W-1:0]          ilvl_o,
  output logic [XLEN-1:0]            epc1_o,
  output logic [XLEN-1:0]            depc_o,
  output logic [CAUSE_W-1:0]         exccause_o,
  output logic [XLEN-1:0]            excvaddr_o,
  output logic [DCAUSE_W-1:0]        dbgcause_o,
  output logic [NLVL*XLEN-1:0]       epc_lvl_o,
  output logic [NLVL*STAT_W-1:0]     eps_lvl_o,
  output logic [1:0]                 vector_o,
  output logic                       redirect_o
);

  localparam logic [ILVL_W-1:0] DL_V = ILVL_W'(DEBUG_LEVEL);

  stat_t stat_q;
  act_e  act;
  vec_e  vec_nxt;
  vec_e  vec_q;
  logic  redir_q;

  exc_arbiter #(.DEBUG_LEVEL(DEBUG_LEVEL)) u_arb (
    .exc_raise (exc_raise),
    .dbg_raise (dbg_raise),
    .stat      (stat_q),
    .act       (act),
    .vec_nxt   (vec_nxt)
  );

  exc_gen_save #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_DEPC(HAS_DEPC)) u_gen (
    .clk         (clk),
    .rst         (rst),
    .take_gen    (act == ACT_GEN),
    .excm_now    (stat_q.excm),
    .pc          (exc_pc),
    .cause       (exc_cause),
    .vaddr_valid (exc_vaddr_valid),
    .vaddr       (exc_vaddr),
    .epc1        (epc1_o),
    .depc        (depc_o),
    .exccause    (exccause_o),
    .excvaddr    (excvaddr_o)
  );

  exc_dbg_save #(.XLEN(XLEN), .DCAUSE_W(DCAUSE_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_dbg (
    .clk      (clk),
    .rst      (rst),
    .take_dbg (act == ACT_DBG),
    .pc       (exc_pc),
    .dcause   (dbg_cause),
    .old_stat (stat_q),
    .dbgcause (dbgcause_o),
    .epc_lvl  (epc_lvl_o),
    .eps_lvl  (eps_lvl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      vec_q   <= VEC_USER;
      redir_q <= 1'b0;
    end else begin
      redir_q <= (act != ACT_NONE);
      if (act != ACT_NONE) vec_q <= vec_nxt;
      case (act)
        ACT_GEN: stat_q.excm <= 1'b1;
        ACT_DBG: begin
          stat_q.excm <= 1'b1;
          stat_q.ilvl <= DL_V;
        end
        default: if (st_wr) stat_q <= stat_t'(st_wdata);
      endcase
    end
  end

  assign excm_o     = stat_q.excm;
  assign um_o       = stat_q.um;
  assign ilvl_o     = stat_q.ilvl;
  assign vector_o   = vec_q;
  assign redirect_o = redir_q;

  // R4
  gen_sets_excm_chk: assert property (@(posedge clk) disable iff (rst)
    exc_raise |=> excm_o);

  // R8
  dbg_level_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_raise && (ilvl_o < DL_V)) |=> (ilvl_o == DL_V) && excm_o && $stable(um_o));

  // R6
  dbg_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_raise && !(ilvl_o < DL_V) && !exc_raise && !st_wr)
      |=> $stable(ilvl_o) && $stable(dbgcause_o) && !redirect_o);

  // R10
  redirect_cause_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(exc_raise || dbg_raise));

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int DL = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         exc_raise = 1'b0;
  logic [5:0]   exc_cause = '0;
  logic [31:0]  exc_pc = '0;
  logic         exc_vaddr_valid = 1'b0;
  logic [31:0]  exc_vaddr = '0;
  logic         dbg_raise = 1'b0;
  logic [5:0]   dbg_cause = '0;
  logic         st_wr = 1'b0;
  logic [4:0]   st_wdata = '0;
  logic         excm_o, um_o;
  logic [2:0]   ilvl_o;
  logic [31:0]  epc1_o, depc_o, excvaddr_o;
  logic [5:0]   exccause_o, dbgcause_o;
  logic [191:0] epc_lvl_o;
  logic [29:0]  eps_lvl_o;
  logic [1:0]   vector_o;
  logic         redirect_o;

  always #2 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .exc_raise(exc_raise), .exc_cause(exc_cause),
    .exc_pc(exc_pc), .exc_vaddr_valid(exc_vaddr_valid), .exc_vaddr(exc_vaddr),
    .dbg_raise(dbg_raise), .dbg_cause(dbg_cause), .st_wr(st_wr), .st_wdata(st_wdata),
    .excm_o(excm_o), .um_o(um_o), .ilvl_o(ilvl_o), .epc1_o(epc1_o), .depc_o(depc_o),
    .exccause_o(exccause_o), .excvaddr_o(excvaddr_o), .dbgcause_o(dbgcause_o),
    .epc_lvl_o(epc_lvl_o), .eps_lvl_o(eps_lvl_o), .vector_o(vector_o),
    .redirect_o(redirect_o)
  );

  typedef struct {
    string        tag;
    logic         excm, um;
    logic [2:0]   ilvl;
    logic [31:0]  epc1, depc, excvaddr;
    logic [5:0]   exccause, dbgcause;
    logic [191:0] epc_lvl;
    logic [29:0]  eps_lvl;
    logic [1:0]   vec;
    logic         red;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  // reference model state
  logic        m_excm, m_um, m_red;
  logic [2:0]  m_ilvl;
  logic [31:0] m_epc1, m_depc, m_excvaddr;
  logic [5:0]  m_exccause, m_dbgcause;
  logic [31:0] m_epc [6];
  logic [4:0]  m_eps [6];
  logic [1:0]  m_vec;

  function automatic exp_t snap(string tag);
    exp_t e;
    e.tag = tag; e.excm = m_excm; e.um = m_um; e.ilvl = m_ilvl;
    e.epc1 = m_epc1; e.depc = m_depc; e.excvaddr = m_excvaddr;
    e.exccause = m_exccause; e.dbgcause = m_dbgcause; e.vec = m_vec; e.red = m_red;
    for (int k = 0; k < 6; k++) begin
      e.epc_lvl[k*32 +: 32] = m_epc[k];
      e.eps_lvl[k*5 +: 5]   = m_eps[k];
    end
    return e;
  endfunction

  task automatic model_reset();
    m_excm = 0; m_um = 0; m_ilvl = 0; m_red = 0; m_vec = 0;
    m_epc1 = 0; m_depc = 0; m_excvaddr = 0; m_exccause = 0; m_dbgcause = 0;
    for (int k = 0; k < 6; k++) begin m_epc[k] = 0; m_eps[k] = 0; end
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; exc_raise = 0; dbg_raise = 0; st_wr = 0; exc_vaddr_valid = 0;
    model_reset();
    q.push_back(snap(tag));
  endtask

  task automatic step(string tag, bit er, logic [5:0] c, logic [31:0] pc, bit vv,
                      logic [31:0] va, bit dr, logic [5:0] dc, bit pw, logic [4:0] pd);
    @(negedge clk);
    rst = 1'b0; exc_raise = er; exc_cause = c; exc_pc = pc; exc_vaddr_valid = vv;
    exc_vaddr = va; dbg_raise = dr; dbg_cause = dc; st_wr = pw; st_wdata = pd;
    if (dr && (m_ilvl < 3'(DL))) begin
      m_dbgcause = dc;
      m_epc[DL-2] = pc;
      m_eps[DL-2] = {m_um, m_excm, m_ilvl};
      m_ilvl = 3'(DL); m_excm = 1; m_vec = 3; m_red = 1;
    end else if (er) begin
      if (vv) m_excvaddr = va;
      m_exccause = c;
      if (m_excm) begin m_depc = pc; m_vec = 2; end
      else begin m_epc1 = pc; m_vec = m_um ? 2'd0 : 2'd1; end
      m_excm = 1; m_red = 1;
    end else begin
      m_red = 0;
      if (pw) begin m_um = pd[4]; m_excm = pd[3]; m_ilvl = pd[2:0]; end
    end
    q.push_back(snap(tag));
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmp(string tag, string fld, logic [191:0] act, logic [191:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s field %s actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        cmp({e.tag, " R4"},  "excm",     192'(excm_o),     192'(e.excm));
        cmp({e.tag, " R11"}, "um",       192'(um_o),       192'(e.um));
        cmp({e.tag, " R8"},  "ilvl",     192'(ilvl_o),     192'(e.ilvl));
        cmp({e.tag, " R2"},  "epc1",     192'(epc1_o),     192'(e.epc1));
        cmp({e.tag, " R3"},  "depc",     192'(depc_o),     192'(e.depc));
        cmp({e.tag, " R4"},  "exccause", 192'(exccause_o), 192'(e.exccause));
        cmp({e.tag, " R5"},  "excvaddr", 192'(excvaddr_o), 192'(e.excvaddr));
        cmp({e.tag, " R7"},  "dbgcause", 192'(dbgcause_o), 192'(e.dbgcause));
        cmp({e.tag, " R7/R12"}, "epc_lvl", epc_lvl_o,      e.epc_lvl);
        cmp({e.tag, " R7/R12"}, "eps_lvl", 192'(eps_lvl_o), 192'(e.eps_lvl));
        cmp({e.tag, " R10"}, "vector",   192'(vector_o),   192'(e.vec));
        cmp({e.tag, " R10"}, "redirect", 192'(redirect_o), 192'(e.red));
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset");
    do_reset("R1 reset hold");
    idle("R1 idle after reset");
    // general, kernel mode
    step("R2 kernel entry", 1, 6'd5, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
    idle("R10 redirect falls");
    // leave exception mode into user mode
    step("R11 status load", 0, 0, 0, 0, 0, 0, 0, 1, 5'b10000);
    step("R2/R5 user entry vaddr", 1, 6'd9, 32'h0000_2004, 1, 32'hDEAD_0000, 0, 0, 0, 0);
    step("R3/R5 double entry no vaddr", 1, 6'd3, 32'h0000_3008, 0, 32'h1111_1111, 0, 0, 0, 0);
    idle("R10 idle");
    step("R11 load dropped on raise", 1, 6'd7, 32'h0000_400C, 1, 32'h0BAD_F00D, 0, 0, 1, 5'b00001);
    step("R11 status load ilvl6", 0, 0, 0, 0, 0, 0, 0, 1, 5'b00110);
    step("R6 debug refused at level", 0, 0, 32'h0000_5000, 0, 0, 1, 6'd2, 0, 0);
    idle("R6 idle");
    step("R11 status load ilvl5 um", 0, 0, 0, 0, 0, 0, 0, 1, 5'b10101);
    step("R9/R8 debug wins", 1, 6'd12, 32'h0000_6010, 1, 32'hCAFE_0000, 1, 6'd4, 0, 0);
    step("R6 refused debug general alone", 1, 6'd13, 32'h0000_7014, 0, 0, 1, 6'd8, 0, 0);
    step("R11 status load clear", 0, 0, 0, 0, 0, 0, 0, 1, 5'b00000);
    step("R7 debug entry from level0", 0, 0, 32'h0000_2222, 0, 0, 1, 6'd33, 0, 0);
    step("R11 status load ilvl7", 0, 0, 0, 0, 0, 0, 0, 1, 5'b00111);
    step("R6 debug refused above level", 0, 0, 32'h0000_8888, 0, 0, 1, 6'd1, 0, 0);
    step("R11 load kernel ilvl1", 0, 0, 0, 0, 0, 0, 0, 1, 5'b00001);
    step("R2 kernel entry again", 1, 6'd63, 32'hFFFF_FFFC, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle("R10 last idle");
    do_reset("R1 reset after activity");
    idle("R1 idle after second reset");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule